// File: doc/BRIEF.md
# Freefall and Motion Event Detector

This block watches a stream of signed three-axis acceleration samples and reports a debounced event. The event is either freefall, where every watched axis stays small, or motion, where any watched axis grows large. Each sample is qualified by a valid strobe. Every axis is compared against one shared unsigned magnitude threshold. An up/down counter then requires the chosen condition to persist for a programmed number of samples before the event flag rises.

Two configuration bits select the behaviour. One chooses freefall or motion. The other chooses whether an event stays set until software acknowledges it with a status-read strobe, or follows the condition on its own. A third bit picks how an unlatched event winds down: the counter either counts back to zero, or is dropped at once. Per-axis flags report the raw, undebounced comparison of each enabled axis. In latched operation these flags freeze together with the event. The interrupt output mirrors the event flag.

Top module: `ffm_detect`

## Requirements
- R1: On each clock edge where `smp_vld` is high, `axis_hi[i]` becomes 1 exactly when axis i (bit 0 = X, 1 = Y, 2 = Z) is enabled and the absolute value of its two's-complement sample is strictly greater than `thresh`. `axis_neg[i]` becomes 1 exactly when axis i is enabled and its sample is negative. Both flags are registered and are visible after that edge.
- R2: With `det_motion` = 0 the condition is that every enabled axis is at or below the threshold. With `det_motion` = 1 the condition is that at least one enabled axis is above it. Disabled axes are ignored, and with `axis_en` = 0 the condition is false, so `evt_active` never sets.
- R3: Starting from a cleared counter, `evt_active` sets at the edge of the `dbc_len`-th consecutive valid sample that meets the condition. With `dbc_len` = 0 it sets on the first such sample.
- R4: Unlatched (`latch_en` = 0) with `dbc_fast` = 0: each valid sample without the condition decrements the counter, floored at 0. Each sample with the condition increments it, saturating at `dbc_len`. An active event clears only when the counter reaches 0, that is, after `dbc_len` samples without the condition when starting from saturation.
- R5: Unlatched with `dbc_fast` = 1: the first valid sample without the condition clears both `evt_active` and the counter. A new event then needs `dbc_len` fresh samples with the condition.
- R6: In unlatched operation `stat_rd` has no effect on the event, the flags or the counter.
- R7: Latched (`latch_en` = 1): once set, `evt_active` stays high whatever the samples until `stat_rd`. A read clears the event and the counter. A sample that arrives in the same cycle as a latched read is discarded.
- R8: In latched operation, while `evt_active` is high, `axis_hi` and `axis_neg` hold the values from the sample that set the event. They follow samples again after a status read.
- R9: `irq` equals `evt_active` at all times.
- R10: A synchronous active-low reset clears `evt_active`, `irq`, `axis_hi`, `axis_neg` and the counter.
- R11: Without `smp_vld` (and without a latched read) the event, the counter and the flags do not change, whatever the sample inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | Sample valid strobe |
| smp_x | input | SAMPLE_W | X sample, signed |
| smp_y | input | SAMPLE_W | Y sample, signed |
| smp_z | input | SAMPLE_W | Z sample, signed |
| thresh | input | SAMPLE_W | Magnitude threshold, unsigned |
| dbc_len | input | CNT_W | Debounce length in samples |
| axis_en | input | 3 | Axis enables, bit 0 = X |
| det_motion | input | 1 | 0 = freefall, 1 = motion |
| latch_en | input | 1 | 1 = event held until status read |
| dbc_fast | input | 1 | 1 = unlatched event drops at once |
| stat_rd | input | 1 | Status read strobe |
| evt_active | output | 1 | Debounced event flag |
| axis_hi | output | 3 | Per-axis above-threshold flags |
| axis_neg | output | 3 | Per-axis negative-sample flags |
| irq | output | 1 | Interrupt level |

## Verification
The assertions assume that the mode bits and `dbc_len` change only between samples, never in the same cycle as a valid sample whose outcome they are meant to govern. The saturation and enable checks compare against the previous cycle's configuration to tolerate such changes. The bench applies every configuration change at a falling edge with `smp_vld` low, or right after a reset. It then sweeps all 256 sample values under several thresholds, including the value whose magnitude just exceeds a threshold of 127. Hand-counted sample sequences cover each of the four modes, both debounce styles and the read/sample collision.

// File: rtl/ffm_pkg.sv
package ffm_pkg;
   localparam int unsigned AXIS_N = 3;

   typedef enum logic {
      DET_FREEFALL = 1'b0,
      DET_MOTION   = 1'b1
   } det_kind_e;

   typedef enum logic {
      EVT_FOLLOW = 1'b0,
      EVT_HOLD   = 1'b1
   } evt_keep_e;
endpackage

// File: rtl/ffm_axis_cmp.sv
module ffm_axis_cmp #(
   parameter int unsigned SAMPLE_W = 8
) (
   input  logic signed [SAMPLE_W-1:0] sample,
   input  logic        [SAMPLE_W-1:0] thresh,
   input  logic                       enable,
   output logic                       high,
   output logic                       negative
);
   // one extra bit so the most negative code has a representable magnitude
   localparam int unsigned MAG_W = SAMPLE_W + 1;

   generate
      if (SAMPLE_W < 2) begin : g_bad_width
         $error("ffm_axis_cmp: SAMPLE_W must be at least 2");
      end
   endgenerate

   logic [MAG_W-1:0] ext;
   logic [MAG_W-1:0] mag;
   logic [MAG_W-1:0] lim;

   assign ext = {sample[SAMPLE_W-1], sample};
   assign mag = ext[MAG_W-1] ? (~ext + 1'b1) : ext;
   assign lim = {1'b0, thresh};

   assign high     = enable & (mag > lim);
   assign negative = enable & sample[SAMPLE_W-1];
endmodule

// File: rtl/ffm_cond_eval.sv
module ffm_cond_eval
   import ffm_pkg::*;
#(
   parameter int unsigned AXES = 3
) (
   input  logic [AXES-1:0] hi_vec,
   input  logic [AXES-1:0] en_vec,
   input  det_kind_e       kind,
   output logic            cond
);
   generate
      if (AXES < 1) begin : g_bad_axes
         $error("ffm_cond_eval: AXES must be at least 1");
      end
   endgenerate

   logic any_active;
   logic any_hi;
   logic all_low;

   // hi_vec arrives already masked by the enables
   assign any_active = |en_vec;
   assign any_hi     = |(hi_vec & en_vec);
   assign all_low    = ~any_hi;

   always_comb begin
      unique case (kind)
         DET_MOTION:   cond = any_active & any_hi;
         DET_FREEFALL: cond = any_active & all_low;
         default:      cond = 1'b0;
      endcase
   end
endmodule

// File: rtl/ffm_debounce.sv
module ffm_debounce
   import ffm_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             cond,
   input  logic [CNT_W-1:0] limit,
   input  logic             fast_clr,
   input  evt_keep_e        keep,
   input  logic             clr,
   output logic             evt
);
   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("ffm_debounce: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_n;
   logic             evt_n;
   logic             hold;

   // a held event freezes the counter until acknowledged
   assign hold = (keep == EVT_HOLD) & evt;

   always_comb begin
      cnt_n = cnt;
      evt_n = evt;
      if (clr) begin
         cnt_n = '0;
         evt_n = 1'b0;
      end else if (step && !hold) begin
         if (cond) begin
            cnt_n = (cnt >= limit) ? limit : cnt + 1'b1;
         end else if (fast_clr) begin
            cnt_n = '0;
         end else begin
            cnt_n = (cnt != '0) ? cnt - 1'b1 : '0;
         end

         if (cond && (cnt_n >= limit)) begin
            evt_n = 1'b1;
         end else if (keep == EVT_FOLLOW) begin
            if (!cond && (fast_clr || (cnt_n == '0))) begin
               evt_n = 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         evt <= 1'b0;
      end else begin
         cnt <= cnt_n;
         evt <= evt_n;
      end
   end

   // R3: a rising event is always caused by a qualifying sample
   p_set_needs_cond_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt) |-> $past(step && cond && !clr));

   // R3/R4: counting up never passes the programmed length
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !hold && !clr && cond) |=> (cnt <= $past(limit)));

   // R11: no strobe, no change
   p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clr) |=> ($stable(cnt) && $stable(evt)));

   // R7: a held event survives anything but a read
   p_hold_until_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((keep == EVT_HOLD) && evt && !clr) |=> evt);

   // R7: a read empties event and counter
   p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!evt && (cnt == '0)));

   // R5: fast mode drops on the first sample without the condition
   p_fast_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && !cond && fast_clr && (keep == EVT_FOLLOW)) |=> (!evt && (cnt == '0)));
endmodule

// File: rtl/ffm_detect.sv
module ffm_detect
   import ffm_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 8,
   parameter int unsigned CNT_W    = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       smp_vld,
   input  logic signed [SAMPLE_W-1:0] smp_x,
   input  logic signed [SAMPLE_W-1:0] smp_y,
   input  logic signed [SAMPLE_W-1:0] smp_z,
   input  logic        [SAMPLE_W-1:0] thresh,
   input  logic        [CNT_W-1:0]    dbc_len,
   input  logic        [2:0]          axis_en,
   input  logic                       det_motion,
   input  logic                       latch_en,
   input  logic                       dbc_fast,
   input  logic                       stat_rd,
   output logic                       evt_active,
   output logic        [2:0]          axis_hi,
   output logic        [2:0]          axis_neg,
   output logic                       irq
);
   localparam int unsigned NAX = AXIS_N;

   logic signed [SAMPLE_W-1:0] smp_arr [NAX];
   logic [NAX-1:0] hi_now;
   logic [NAX-1:0] neg_now;
   logic [NAX-1:0] hi_q;
   logic [NAX-1:0] neg_q;
   logic           cond;
   logic           evt;
   logic           rd_clr;
   logic           flag_upd;
   det_kind_e      kind;
   evt_keep_e      keep;

   assign smp_arr[0] = smp_x;
   assign smp_arr[1] = smp_y;
   assign smp_arr[2] = smp_z;

   assign kind = det_motion ? DET_MOTION : DET_FREEFALL;
   assign keep = latch_en ? EVT_HOLD : EVT_FOLLOW;

   generate
      for (genvar i = 0; i < NAX; i++) begin : g_axis
         ffm_axis_cmp #(
            .SAMPLE_W (SAMPLE_W)
         ) u_cmp (
            .sample   (smp_arr[i]),
            .thresh   (thresh),
            .enable   (axis_en[i]),
            .high     (hi_now[i]),
            .negative (neg_now[i])
         );
      end
   endgenerate

   ffm_cond_eval #(
      .AXES (NAX)
   ) u_cond (
      .hi_vec (hi_now),
      .en_vec (axis_en),
      .kind   (kind),
      .cond   (cond)
   );

   // a read only acts in latched operation; its cycle's sample is dropped
   assign rd_clr = (keep == EVT_HOLD) & stat_rd;

   ffm_debounce #(
      .CNT_W (CNT_W)
   ) u_dbc (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (smp_vld),
      .cond     (cond),
      .limit    (dbc_len),
      .fast_clr (dbc_fast),
      .keep     (keep),
      .clr      (rd_clr),
      .evt      (evt)
   );

   assign flag_upd = smp_vld & ~((keep == EVT_HOLD) & (evt | stat_rd));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q  <= '0;
         neg_q <= '0;
      end else if (flag_upd) begin
         hi_q  <= hi_now;
         neg_q <= neg_now;
      end
   end

   assign evt_active = evt;
   assign irq        = evt;
   assign axis_hi    = hi_q;
   assign axis_neg   = neg_q;

   // R8: flags frozen while a latched event waits for a read
   p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en && evt && !stat_rd) |=> ($stable(axis_hi) && $stable(axis_neg)));

   // R6: a read without a sample changes nothing when unlatched
   p_read_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_en && stat_rd && !smp_vld) |=> $stable(evt_active));

   // R1: a disabled axis never reports
   p_flags_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
      flag_upd |=> (((axis_hi | axis_neg) & ~$past(axis_en)) == '0));

   // R2: with every axis off no event may rise
   p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(axis_en) == '0) |-> !$rose(evt_active));
endmodule

// File: tb/sim_ffm_detect.sv
module sim_ffm_detect;
   localparam int CLK_PERIOD = 10;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              vld;
   logic signed [7:0] sx, sy, sz;
   logic        [7:0] th;
   logic        [7:0] dlen;
   logic        [2:0] en;
   logic              motion, latch, fast, rd;
   logic              evt, irq;
   logic        [2:0] hi, neg;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ffm_detect u0 (
      .clk(clk), .rst_n(rst_n), .smp_vld(vld),
      .smp_x(sx), .smp_y(sy), .smp_z(sz),
      .thresh(th), .dbc_len(dlen), .axis_en(en),
      .det_motion(motion), .latch_en(latch), .dbc_fast(fast),
      .stat_rd(rd), .evt_active(evt), .axis_hi(hi), .axis_neg(neg), .irq(irq)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_evt(input string req, input int exp);
      check(req, evt, exp);
      check({req, " R9 irq"}, irq, exp);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; vld = 1'b0; rd = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic put(input logic signed [7:0] x, input logic signed [7:0] y,
                      input logic signed [7:0] z, input logic with_rd);
      @(negedge clk);
      sx = x; sy = y; sz = z; vld = 1'b1; rd = with_rd;
      @(negedge clk);
      vld = 1'b0; rd = 1'b0;
   endtask

   task automatic read_only();
      @(negedge clk);
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; vld = 1'b0; rd = 1'b0;
      sx = 0; sy = 0; sz = 0;
      th = 8'd20; dlen = 8'd3; en = 3'b111;
      motion = 1'b1; latch = 1'b0; fast = 1'b1;
      do_reset();

      // R10 reset state
      chk_evt("R10 reset evt", 0);
      check("R10 reset hi", hi, 0);
      check("R10 reset neg", neg, 0);

      // R3 motion, unlatched, N=3
      put(50, 0, 0, 0); chk_evt("R3 sample1", 0);
      put(50, 0, 0, 0); chk_evt("R3 sample2", 0);
      put(50, 0, 0, 0); chk_evt("R3 sample3", 1);
      check("R1 hi after motion", hi, 3'b001);

      // R6 read has no effect when unlatched
      read_only(); chk_evt("R6 read ignored", 1);

      // R5 fast drop and fresh period
      put(0, 0, 0, 0);  chk_evt("R5 drop", 0);
      put(50, 0, 0, 0); chk_evt("R5 refill1", 0);
      put(50, 0, 0, 0); chk_evt("R5 refill2", 0);
      put(50, 0, 0, 0); chk_evt("R5 refill3", 1);

      // R4 decrement mode
      @(negedge clk); fast = 1'b0;
      put(0, 0, 0, 0); chk_evt("R4 down1", 1);
      put(0, 0, 0, 0); chk_evt("R4 down2", 1);
      put(0, 0, 0, 0); chk_evt("R4 down3", 0);
      put(50, 0, 0, 0); chk_evt("R4 up1", 0);
      put(50, 0, 0, 0); chk_evt("R4 up2", 0);
      put(0, 0, 0, 0);  chk_evt("R4 partial decay", 0);
      put(50, 0, 0, 0); chk_evt("R4 up again", 0);
      put(50, 0, 0, 0); chk_evt("R4 reaches limit", 1);
      put(0, 0, 0, 0); put(0, 0, 0, 0); put(0, 0, 0, 0);
      chk_evt("R4 decayed", 0);

      // R11 no strobe: inputs wiggle, nothing moves
      @(negedge clk); sx = 90; sy = -90; sz = 90;
      repeat (5) @(negedge clk);
      chk_evt("R11 idle evt", 0);
      check("R11 idle hi", hi, 0);
      check("R11 idle neg", neg, 0);

      // R3 zero-length debounce
      do_reset();
      dlen = 8'd0; fast = 1'b1;
      put(-60, 0, 0, 0); chk_evt("R3 N=0 set", 1);
      check("R1 neg x", neg, 3'b001);
      put(0, 0, 0, 0);   chk_evt("R3 N=0 clear", 0);

      // R2 freefall over X,Y only
      do_reset();
      motion = 1'b0; en = 3'b011; dlen = 8'd2; fast = 1'b1;
      put(5, -5, 100, 0); chk_evt("R2 ff1", 0);
      check("R2 z ignored hi", hi, 0);
      check("R1 neg y only", neg, 3'b010);
      put(5, -5, 100, 0); chk_evt("R2 ff2", 1);
      put(30, 0, 0, 0);   chk_evt("R2 ff broken", 0);
      check("R1 hi x", hi, 3'b001);

      // R2 motion on disabled axes only
      do_reset();
      motion = 1'b1; en = 3'b001; dlen = 8'd1;
      for (int k = 0; k < 3; k++) put(0, 100, -100, 0);
      chk_evt("R2 disabled axes motion", 0);
      check("R2 disabled axes hi", hi, 0);

      // R2 all axes off
      do_reset();
      motion = 1'b0; en = 3'b000; dlen = 8'd1;
      for (int k = 0; k < 3; k++) put(0, 0, 0, 0);
      chk_evt("R2 all disabled", 0);

      // R7 / R8 latched
      do_reset();
      latch = 1'b1; motion = 1'b1; en = 3'b111; dlen = 8'd2; fast = 1'b1; th = 8'd20;
      put(50, 0, 0, 0); chk_evt("R7 l1", 0);
      put(50, 0, 0, 0); chk_evt("R7 l2", 1);
      check("R8 hi at set", hi, 3'b001);
      put(0, -70, 0, 0); chk_evt("R7 held", 1);
      check("R8 hi frozen", hi, 3'b001);
      check("R8 neg frozen", neg, 3'b000);
      put(0, 0, 0, 0); put(0, 0, 0, 0);
      chk_evt("R7 held quiet", 1);
      read_only(); chk_evt("R7 read clears", 0);
      put(0, -70, 0, 0); chk_evt("R7 fresh1", 0);
      check("R8 hi resumed", hi, 3'b010);
      check("R8 neg resumed", neg, 3'b010);
      put(0, -70, 0, 0); chk_evt("R7 fresh2", 1);
      put(0, -70, 0, 1); chk_evt("R7 read with sample", 0);
      put(0, -70, 0, 0); chk_evt("R7 sample discarded", 0);
      put(0, -70, 0, 0); chk_evt("R7 after collision", 1);

      // R10 reset mid-event
      do_reset();
      chk_evt("R10 mid reset evt", 0);
      check("R10 mid reset hi", hi, 0);
      check("R10 mid reset neg", neg, 0);

      // R1 sweep of every sample code
      latch = 1'b0; motion = 1'b1; en = 3'b101; dlen = 8'd255;
      foreach (th_list[t]) begin
         @(negedge clk); th = th_list[t];
         for (int v = -128; v < 128; v++) begin
            int mag;
            logic [5:0] exp_flags;
            mag = (v < 0) ? -v : v;
            exp_flags = {((mag > th_list[t]) ? 3'b101 : 3'b000),
                         ((v < 0) ? 3'b101 : 3'b000)};
            put(8'(v), 8'(v), 8'(v), 0);
            check("R1 sweep", {hi, neg}, exp_flags);
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   int th_list [4] = '{0, 37, 127, 200};
endmodule